// File: doc/BRIEF.md
# Microcontroller data memory space decoder

This block is the data-memory subsystem behind an 8-bit microcontroller core. Every data access from the core carries an address, a read strobe and a write strobe, write data, and an access-type code. From these the block picks one of five places. These are a lower 128-byte internal RAM, an upper 128-byte internal RAM, the special function register (SFR) bus, a local auxiliary control register, or a 256-byte on-chip expanded RAM. Addresses 0x80–0xFF exist twice inside the core. The access type alone decides whether such an address reaches the SFR bus or the upper RAM.

Expanded-RAM accesses use either an 8-bit pointer or a 16-bit pointer. The expanded RAM is always enabled. Nothing on the pins changes during these accesses. A 16-bit pointer past the end of the array is dropped on a write and returns a fixed filler byte on a read. Stack pushes and pops use the stack pointer as an indirect internal address.

Reads complete one cycle after the request, and a valid flag marks them. SFR reads use the same one-cycle return.

Top module: `dmem_space`

## Requirements
- R1: Access codes are 0 direct, 1 indirect, 2 stack, 3 expanded with 8-bit pointer, 4 expanded with 16-bit pointer. For direct and indirect accesses, addresses 0x00–0x7F (low byte of `addr_i`) reach one shared lower RAM.
- R2: Indirect accesses to 0x80–0xFF reach an upper RAM that is kept apart from the SFR space. A direct write to the same address leaves the upper RAM unchanged.
- R3: Direct accesses to 0x80–0xFF other than the auxiliary address 0x8E raise `sfr_req_o` during the request cycle. The same cycle carries `sfr_addr_o`, `sfr_wdata_o`, and `sfr_we_o` equal to the write strobe. For a read, `rdata_o` on the following cycle equals the `sfr_rdata_i` value sampled during the request.
- R4: Accesses with codes 3 and 4 reach a 256-byte expanded RAM that is separate from the internal RAMs. A 16-bit pointer at or below 0x00FF addresses the same byte as an 8-bit pointer with that value.
- R5: A code-4 write whose address is 0x0100–0xFFFF changes no storage.
- R6: A code-4 read whose address is 0x0100–0xFFFF returns 0xFF with `rvalid_o` high.
- R7: Direct address 0x8E is a local auxiliary register. It reads back what was written, it never drives the SFR bus, and writing 1 to its bit 1 does not disable the expanded RAM.
- R8: `ext_rd_o` and `ext_wr_o` stay low at all times. Expanded-RAM and stack accesses never raise `sfr_req_o`.
- R9: Stack accesses use the low address byte as an indirect internal address: lower RAM below 0x80, upper RAM otherwise. They never touch the expanded RAM.
- R10: `rvalid_o` is high exactly in the cycle after a read request and low otherwise. `rdata_o` reads 0 while `rvalid_o` is low.
- R11: When `rd_i` and `wr_i` are both high, the write is performed and no read response follows.
- R12: After reset, `rvalid_o` and `sfr_req_o` are low and the auxiliary register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rd_i | input | 1 | Read request |
| wr_i | input | 1 | Write request |
| acc_i | input | 3 | Access type code |
| addr_i | input | 16 | Access address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid with rvalid_o |
| rvalid_o | output | 1 | Read data valid, one cycle after request |
| sfr_req_o | output | 1 | SFR bus request |
| sfr_we_o | output | 1 | SFR bus write enable |
| sfr_addr_o | output | 8 | SFR bus address |
| sfr_wdata_o | output | 8 | SFR bus write data |
| sfr_rdata_i | input | 8 | SFR bus read data |
| ext_rd_o | output | 1 | External read strobe, never asserted |
| ext_wr_o | output | 1 | External write strobe, never asserted |

## Verification
On every cycle, the assertions check the following:
- SFR requests appear only for direct upper-half addresses and always appear for them.
- The read-valid timing holds, and a combined read and write produces no read response.
- SFR read data returns one cycle after the request.
- Out-of-range 16-bit expanded reads return the filler byte.
- Expanded-RAM and stack accesses stay off the SFR bus.

Storage claims need the directed scenarios, which write and then read back. These claims are that direct and indirect accesses share the lower RAM, that the upper RAM is separate from the SFRs, that the expanded RAM is separate from internal RAM, that dropped out-of-range writes leave aliased bytes unchanged, and that the auxiliary bit leaves the expanded RAM working.

// File: rtl/dmem_pkg.sv
package dmem_pkg;
  localparam int unsigned DATA_W  = 8;
  localparam int unsigned ADDR_W  = 16;
  localparam int unsigned IADDR_W = 8;
  localparam int unsigned IRAM_AW = IADDR_W - 1;

  typedef enum logic [2:0] {
    ACC_DIRECT = 3'd0,
    ACC_INDIR  = 3'd1,
    ACC_STACK  = 3'd2,
    ACC_X8     = 3'd3,
    ACC_X16    = 3'd4
  } acc_e;

  typedef enum logic [2:0] {
    TGT_NONE = 3'd0,
    TGT_LO   = 3'd1,
    TGT_UP   = 3'd2,
    TGT_SFR  = 3'd3,
    TGT_AUX  = 3'd4,
    TGT_XRAM = 3'd5
  } tgt_e;
endpackage

// File: rtl/dmem_decode.sv
module dmem_decode
  import dmem_pkg::*;
#(
  parameter int unsigned XRAM_AW  = 8,
  parameter logic [7:0]  AUX_ADDR = 8'h8E
) (
  input  logic [2:0]        acc_i,
  input  logic [ADDR_W-1:0] addr_i,
  output tgt_e              tgt_o
);
  localparam int unsigned XRAM_LIMIT = 1 << XRAM_AW;

  logic [IADDR_W-1:0] ia;
  logic               hi_half;
  logic               x16_in, x8_in;

  assign ia      = addr_i[IADDR_W-1:0];
  assign hi_half = ia[IADDR_W-1];
  assign x16_in  = 32'(addr_i) < XRAM_LIMIT;
  assign x8_in   = 32'(ia) < XRAM_LIMIT;

  always_comb begin
    tgt_o = TGT_NONE;
    unique case (acc_i)
      ACC_DIRECT: begin
        if (!hi_half)            tgt_o = TGT_LO;
        else if (ia == AUX_ADDR) tgt_o = TGT_AUX;
        else                     tgt_o = TGT_SFR;
      end
      // stack shares the indirect map; never reaches expanded RAM
      ACC_INDIR, ACC_STACK: tgt_o = hi_half ? TGT_UP : TGT_LO;
      ACC_X8:  tgt_o = x8_in  ? TGT_XRAM : TGT_NONE;
      ACC_X16: tgt_o = x16_in ? TGT_XRAM : TGT_NONE;
      default: tgt_o = TGT_NONE;
    endcase
  end
endmodule

// File: rtl/dmem_ram.sv
module dmem_ram #(
  parameter int unsigned AW = 7,
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic          re_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] q;

  always_ff @(posedge clk_i) begin
    if (we_i) mem[addr_i] <= wdata_i;
    if (re_i) q <= mem[addr_i];
  end

  assign rdata_o = q;
endmodule

// File: rtl/dmem_space.sv
module dmem_space
  import dmem_pkg::*;
#(
  parameter int unsigned XRAM_AW   = 8,
  parameter logic [7:0]  AUX_ADDR  = 8'h8E,
  parameter logic [7:0]  AUX_WMASK = 8'hFF,
  parameter logic [7:0]  OOR_DATA  = 8'hFF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [2:0]        acc_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o,
  output logic              sfr_req_o,
  output logic              sfr_we_o,
  output logic [7:0]        sfr_addr_o,
  output logic [DATA_W-1:0] sfr_wdata_o,
  input  logic [DATA_W-1:0] sfr_rdata_i,
  output logic              ext_rd_o,
  output logic              ext_wr_o
);
  localparam int unsigned NBANK = 2;

  tgt_e              tgt;
  logic              rd_en;
  logic [DATA_W-1:0] iram_q [NBANK];
  logic [DATA_W-1:0] xram_q;
  logic [DATA_W-1:0] aux_q;
  logic [DATA_W-1:0] side_q;
  tgt_e              src_q;
  logic              rvalid_q;

  // write wins over a simultaneous read
  assign rd_en = rd_i & ~wr_i;

  dmem_decode #(.XRAM_AW(XRAM_AW), .AUX_ADDR(AUX_ADDR)) u_dec (
    .acc_i (acc_i),
    .addr_i(addr_i),
    .tgt_o (tgt)
  );

  for (genvar b = 0; b < NBANK; b++) begin : gen_iram
    localparam tgt_e BANK_TGT = (b == 0) ? TGT_LO : TGT_UP;
    dmem_ram #(.AW(IRAM_AW), .DW(DATA_W)) u_ram (
      .clk_i  (clk_i),
      .we_i   (wr_i  && tgt == BANK_TGT),
      .re_i   (rd_en && tgt == BANK_TGT),
      .addr_i (addr_i[IRAM_AW-1:0]),
      .wdata_i(wdata_i),
      .rdata_o(iram_q[b])
    );
  end

  dmem_ram #(.AW(XRAM_AW), .DW(DATA_W)) u_xram (
    .clk_i  (clk_i),
    .we_i   (wr_i  && tgt == TGT_XRAM),
    .re_i   (rd_en && tgt == TGT_XRAM),
    .addr_i (addr_i[XRAM_AW-1:0]),
    .wdata_i(wdata_i),
    .rdata_o(xram_q)
  );

  assign sfr_req_o   = (rd_i | wr_i) && tgt == TGT_SFR;
  assign sfr_we_o    = wr_i && tgt == TGT_SFR;
  assign sfr_addr_o  = addr_i[7:0];
  assign sfr_wdata_o = wdata_i;

  // expanded RAM is on-chip only: no external strobes exist
  assign ext_rd_o = 1'b0;
  assign ext_wr_o = 1'b0;

  // aux bits are plain storage; none gates the expanded RAM
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        aux_q <= '0;
    else if (wr_i && tgt == TGT_AUX)    aux_q <= wdata_i & AUX_WMASK;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_q <= 1'b0;
      src_q    <= TGT_NONE;
      side_q   <= '0;
    end else begin
      rvalid_q <= rd_en;
      if (rd_en) begin
        src_q <= tgt;
        unique case (tgt)
          TGT_SFR: side_q <= sfr_rdata_i;
          TGT_AUX: side_q <= aux_q;
          default: side_q <= OOR_DATA;
        endcase
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rvalid_q) begin
      unique case (src_q)
        TGT_LO:   rdata_o = iram_q[0];
        TGT_UP:   rdata_o = iram_q[1];
        TGT_XRAM: rdata_o = xram_q;
        default:  rdata_o = side_q;
      endcase
    end
  end

  assign rvalid_o = rvalid_q;
endmodule

// File: rtl/dmem_space_chk.sv
module dmem_space_chk
  import dmem_pkg::*;
#(
  parameter logic [7:0] AUX_ADDR = 8'h8E,
  parameter logic [7:0] OOR_DATA = 8'hFF
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rd_i,
  input logic              wr_i,
  input logic [2:0]        acc_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              rvalid_o,
  input logic              sfr_req_o,
  input logic              sfr_we_o,
  input logic [DATA_W-1:0] sfr_rdata_i
);
  logic sfr_hit;
  assign sfr_hit = acc_i == ACC_DIRECT && addr_i[7] && addr_i[7:0] != AUX_ADDR;

  assert_rvalid_after_read_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !wr_i) |=> rvalid_o);

  assert_rvalid_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_i && !wr_i) |=> !rvalid_o);

  assert_write_wins_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && wr_i) |=> !rvalid_o);

  assert_sfr_only_direct_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sfr_req_o |-> sfr_hit);

  assert_sfr_on_direct_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rd_i || wr_i) && sfr_hit) |-> (sfr_req_o && sfr_we_o == wr_i));

  assert_sfr_read_return_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sfr_req_o && rd_i && !wr_i) |=> rdata_o == $past(sfr_rdata_i));

  assert_xram_no_sfr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i == ACC_X8 || acc_i == ACC_X16) |-> !sfr_req_o);

  assert_stack_no_sfr_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_i == ACC_STACK |-> !sfr_req_o);

  assert_oor_read_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !wr_i && acc_i == ACC_X16 && addr_i[15:8] != 8'h00) |=> rdata_o == OOR_DATA);
endmodule

bind dmem_space dmem_space_chk #(.AUX_ADDR(AUX_ADDR), .OOR_DATA(OOR_DATA)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rd_i       (rd_i),
  .wr_i       (wr_i),
  .acc_i      (acc_i),
  .addr_i     (addr_i),
  .rdata_o    (rdata_o),
  .rvalid_o   (rvalid_o),
  .sfr_req_o  (sfr_req_o),
  .sfr_we_o   (sfr_we_o),
  .sfr_rdata_i(sfr_rdata_i)
);

// File: tb/dmem_space_bench.sv
module dmem_space_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [2:0] A_DIR = 3'd0, A_IND = 3'd1, A_STK = 3'd2, A_X8 = 3'd3, A_X16 = 3'd4;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        rd_i = 1'b0, wr_i = 1'b0;
  logic [2:0]  acc_i = '0;
  logic [15:0] addr_i = '0;
  logic [7:0]  wdata_i = '0;
  logic [7:0]  rdata_o, sfr_addr_o, sfr_wdata_o, sfr_rdata_i;
  logic        rvalid_o, sfr_req_o, sfr_we_o, ext_rd_o, ext_wr_o;

  int checks = 0, fails = 0;
  int sfr_n = 0, ext_n = 0;
  logic [7:0] sfr_last_addr, sfr_last_data;
  logic       sfr_last_we;

  always #(CLK_PERIOD/2) clk = ~clk;

  dmem_space u_dmem_space (
    .clk_i(clk), .rst_ni(rst_ni), .rd_i(rd_i), .wr_i(wr_i), .acc_i(acc_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .rvalid_o(rvalid_o),
    .sfr_req_o(sfr_req_o), .sfr_we_o(sfr_we_o), .sfr_addr_o(sfr_addr_o),
    .sfr_wdata_o(sfr_wdata_o), .sfr_rdata_i(sfr_rdata_i),
    .ext_rd_o(ext_rd_o), .ext_wr_o(ext_wr_o)
  );

  // SFR bus model: read data derived from address
  assign sfr_rdata_i = sfr_addr_o ^ 8'h5A;

  always @(posedge clk) begin
    if (sfr_req_o) begin
      sfr_n++;
      sfr_last_addr = sfr_addr_o;
      sfr_last_data = sfr_wdata_o;
      sfr_last_we   = sfr_we_o;
    end
    if (ext_rd_o || ext_wr_o) ext_n++;
  end

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr_op(input logic [2:0] acc, input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_i = 1'b1; rd_i = 1'b0; acc_i = acc; addr_i = a; wdata_i = d;
    @(negedge clk);
    wr_i = 1'b0;
  endtask

  task automatic rd_op(input logic [2:0] acc, input logic [15:0] a,
                       output logic [7:0] d, output logic v);
    @(negedge clk);
    rd_i = 1'b1; wr_i = 1'b0; acc_i = acc; addr_i = a;
    @(negedge clk);
    rd_i = 1'b0;
    v = rvalid_o;
    d = rdata_o;
  endtask

  task automatic rd_chk(input string tag, input logic [2:0] acc, input logic [15:0] a,
                        input logic [7:0] exp);
    logic [7:0] d;
    logic v;
    rd_op(acc, a, d, v);
    check({tag, " valid"}, 16'(v), 16'd1);
    check(tag, 16'(d), 16'(exp));
  endtask

  task automatic t_reset;
    check("R12 rvalid", 16'(rvalid_o), 16'd0);
    check("R12 sfr_req", 16'(sfr_req_o), 16'd0);
    rd_chk("R12 aux", A_DIR, 16'h008E, 8'h00);
  endtask

  task automatic t_lower;
    wr_op(A_DIR, 16'h0010, 8'hA1);
    rd_chk("R1 dir->ind", A_IND, 16'h0010, 8'hA1);
    wr_op(A_IND, 16'h007F, 8'h3C);
    rd_chk("R1 ind->dir", A_DIR, 16'h007F, 8'h3C);
  endtask

  task automatic t_upper_sfr;
    int n0;
    logic [7:0] d;
    logic v;
    wr_op(A_IND, 16'h0090, 8'h77);
    n0 = sfr_n;
    check("R2 ind no sfr", 16'(sfr_n - n0), 16'd0);
    wr_op(A_DIR, 16'h0090, 8'h11);
    check("R3 sfr wr count", 16'(sfr_n - n0), 16'd1);
    check("R3 sfr wr addr", 16'(sfr_last_addr), 16'h0090);
    check("R3 sfr wr data", 16'(sfr_last_data), 16'h0011);
    check("R3 sfr wr we", 16'(sfr_last_we), 16'd1);
    rd_chk("R2 upper intact", A_IND, 16'h0090, 8'h77);
    n0 = sfr_n;
    rd_op(A_DIR, 16'h00A0, d, v);
    check("R3 sfr rd valid", 16'(v), 16'd1);
    check("R3 sfr rd data", 16'(d), 16'h00FA);
    check("R3 sfr rd pulse", 16'(sfr_n - n0), 16'd1);
    check("R3 sfr rd we", 16'(sfr_last_we), 16'd0);
  endtask

  task automatic t_xram;
    int n0;
    n0 = sfr_n;
    wr_op(A_X8, 16'h0010, 8'hC3);
    rd_chk("R4 iram separate", A_IND, 16'h0010, 8'hA1);
    rd_chk("R4 x16 alias", A_X16, 16'h0010, 8'hC3);
    wr_op(A_X16, 16'h00FF, 8'h99);
    rd_chk("R4 x8 top", A_X8, 16'h00FF, 8'h99);
    check("R8 xram no sfr", 16'(sfr_n - n0), 16'd0);
  endtask

  task automatic t_xhigh;
    wr_op(A_X16, 16'h1210, 8'hEE);
    rd_chk("R5 alias intact", A_X8, 16'h0010, 8'hC3);
    wr_op(A_X16, 16'hFFFF, 8'h01);
    rd_chk("R5 top intact", A_X16, 16'h00FF, 8'h99);
    rd_chk("R6 oor read", A_X16, 16'h1210, 8'hFF);
    rd_chk("R6 oor read 0x100", A_X16, 16'h0100, 8'hFF);
  endtask

  task automatic t_aux;
    int n0;
    n0 = sfr_n;
    wr_op(A_DIR, 16'h008E, 8'h02);
    rd_chk("R7 aux readback", A_DIR, 16'h008E, 8'h02);
    check("R7 aux no sfr", 16'(sfr_n - n0), 16'd0);
    wr_op(A_X8, 16'h0042, 8'h5C);
    rd_chk("R7 xram still on", A_X8, 16'h0042, 8'h5C);
  endtask

  task automatic t_stack;
    int n0;
    wr_op(A_X8, 16'h0020, 8'h66);
    n0 = sfr_n;
    wr_op(A_STK, 16'h0020, 8'h44);
    rd_chk("R9 stack low", A_IND, 16'h0020, 8'h44);
    wr_op(A_STK, 16'h00C0, 8'h55);
    rd_chk("R9 stack up", A_IND, 16'h00C0, 8'h55);
    rd_chk("R9 stack pop", A_STK, 16'h0020, 8'h44);
    rd_chk("R9 xram intact", A_X8, 16'h0020, 8'h66);
    check("R9 stack no sfr", 16'(sfr_n - n0), 16'd0);
  endtask

  task automatic t_prio;
    @(negedge clk);
    rd_i = 1'b1; wr_i = 1'b1; acc_i = A_IND; addr_i = 16'h0030; wdata_i = 8'h12;
    @(negedge clk);
    rd_i = 1'b0; wr_i = 1'b0;
    check("R11 no rvalid", 16'(rvalid_o), 16'd0);
    rd_chk("R11 write done", A_IND, 16'h0030, 8'h12);
  endtask

  task automatic t_latency;
    rd_chk("R10 read", A_IND, 16'h0010, 8'hA1);
    @(negedge clk);
    check("R10 idle rvalid", 16'(rvalid_o), 16'd0);
    check("R10 idle rdata", 16'(rdata_o), 16'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    t_reset();
    t_lower();
    t_upper_sfr();
    t_xram();
    t_xhigh();
    t_aux();
    t_stack();
    t_prio();
    t_latency();
    check("R8 ext strobes", 16'(ext_n), 16'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule